// File: doc/BRIEF.md
# Crossbar Word Rotator

This block rotates a data word to the right by any amount from zero to one less than the word width, and does it in one pass through combinational logic. The rotation amount arrives as a binary count. A decoder turns the count into a single active select line for each possible amount. Each select line enables one diagonal of a square grid of crosspoints, and each crosspoint joins one input bit to one output bit. Every output bit is therefore chosen in one level of selection, whatever the word width.

The crosspoints stand in for switched connections. Each crosspoint is an AND term, and the terms that reach each output bit are OR-merged. Because exactly one diagonal is enabled, each output column has exactly one active term. The block has no clock and no state. A surrounding datapath places it wherever a rotate by a variable amount must settle within one cycle.

Top module: `xbar_rotator`

## Requirements
- R1: For a width N and a count k, output bit j equals input bit (j + k) mod N. This is a rotate toward bit 0, and bits that leave bit 0 re-enter at bit N-1.
- R2: A count of 0 passes the input word to the output unchanged.
- R3: For every count value k, the decoder asserts exactly one select line, and that line is line k. As a result, a word with a single set bit at position i produces a single set bit at position (i - k) mod N.
- R4: Every output bit has exactly one enabled crosspoint for every count. An all-ones input gives all ones at the output and an all-zeros input gives all zeros.
- R5: The output follows a change on the data or count inputs without any clock edge, within the same time step.
- R6: The output holds the same number of set bits as the input for every count and every data pattern.
- R7: The width parameter WIDTH (a power of two, default 8) scales the block. The count port is log2(WIDTH) bits wide, and R1 holds for WIDTH = 16 with a 4-bit count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to be rotated |
| amt_i | input | log2(WIDTH) | Rotation amount, unsigned binary |
| data_o | output | WIDTH | Word rotated right by amt_i |

## Verification
The checker evaluates its immediate assertions whenever the inputs change. It takes for granted that both inputs hold known values and that WIDTH is a power of two, so every count value names a valid rotation and decodes to exactly one line. The stimulus drives only defined values and walks every count for each width it instantiates. It changes the inputs between clock edges and samples after a short settle delay, so each comparison sees the finished combinational result.

// File: rtl/xrot_pkg.sv
`timescale 1ns/1ps
package xrot_pkg;

  // Modular index into a word of n bits; handles negative offsets.
  function automatic int wrap_idx(input int a, input int n);
    int r;
    r = a % n;
    if (r < 0) r = r + n;
    return r;
  endfunction

  // Which rotation amount connects input bit src to output bit dst.
  function automatic int diag_of(input int dst, input int src, input int n);
    return wrap_idx(src - dst, n);
  endfunction

  // Width of a count that spans n values.
  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rot_count_decoder.sv
`timescale 1ns/1ps
module rot_count_decoder #(
  parameter int N  = 8,
  parameter int CW = 3
) (
  input  logic [CW-1:0] amt,
  output logic [N-1:0]  sel
);
  // One select line per rotation amount.
  for (genvar k = 0; k < N; k++) begin : g_line
    assign sel[k] = (amt == CW'(k));
  end
endmodule

// File: rtl/rot_crosspoint_grid.sv
`timescale 1ns/1ps
module rot_crosspoint_grid #(
  parameter int N = 8
) (
  input  logic [N-1:0]        data,
  input  logic [N-1:0]        sel,
  output logic [N-1:0][N-1:0] en,    // en[dst][src]
  output logic [N-1:0][N-1:0] term   // gated input bit at each crosspoint
);
  import xrot_pkg::*;

  for (genvar j = 0; j < N; j++) begin : g_col
    for (genvar i = 0; i < N; i++) begin : g_row
      localparam int K = diag_of(j, i, N);
      assign en[j][i]   = sel[K];
      assign term[j][i] = data[i] & en[j][i];
    end
  end
endmodule

// File: rtl/rot_output_merge.sv
`timescale 1ns/1ps
module rot_output_merge #(
  parameter int N = 8
) (
  input  logic [N-1:0][N-1:0] term,
  output logic [N-1:0]        y
);
  // Wired-OR replacement: each output column ORs its crosspoint terms.
  for (genvar j = 0; j < N; j++) begin : g_out
    assign y[j] = |term[j];
  end
endmodule

// File: rtl/xbar_rotator.sv
`timescale 1ns/1ps
module xbar_rotator #(
  parameter int WIDTH = 8,
  localparam int CW   = xrot_pkg::cnt_bits(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [CW-1:0]    amt_i,
  output logic [WIDTH-1:0] data_o
);
  // Named internal events for the checker.
  logic [WIDTH-1:0]            amt_sel;
  logic [WIDTH-1:0][WIDTH-1:0] xp_en;
  logic [WIDTH-1:0][WIDTH-1:0] xp_term;

  rot_count_decoder #(.N(WIDTH), .CW(CW)) u_dec (
    .amt (amt_i),
    .sel (amt_sel)
  );

  rot_crosspoint_grid #(.N(WIDTH)) u_grid (
    .data (data_i),
    .sel  (amt_sel),
    .en   (xp_en),
    .term (xp_term)
  );

  rot_output_merge #(.N(WIDTH)) u_merge (
    .term (xp_term),
    .y    (data_o)
  );
endmodule

// File: rtl/xbar_rotator_chk.sv
`timescale 1ns/1ps
module xbar_rotator_chk #(
  parameter int WIDTH = 8,
  localparam int CW   = xrot_pkg::cnt_bits(WIDTH)
) (
  input logic [WIDTH-1:0]            data_i,
  input logic [CW-1:0]               amt_i,
  input logic [WIDTH-1:0]            data_o,
  input logic [WIDTH-1:0]            sel,
  input logic [WIDTH-1:0][WIDTH-1:0] en
);
  logic [2*WIDTH-1:0] dbl;
  logic [WIDTH-1:0]   ref_rot;

  always_comb begin
    dbl     = {data_i, data_i} >> amt_i;
    ref_rot = dbl[WIDTH-1:0];
  end

  always_comb begin
    AST_ROT_VALUE: assert (data_o == ref_rot) else $error("rotate mismatch"); // R1
    AST_ZERO_PASS: assert (amt_i != '0 || data_o == data_i) else $error("count 0 altered word"); // R2
    AST_SEL_ONEHOT: assert ($onehot(sel)) else $error("decoder not one-hot"); // R3
    AST_SEL_MATCH: assert (sel[amt_i]) else $error("wrong decoder line"); // R3
    AST_POP_KEEP: assert ($countones(data_o) == $countones(data_i)) else $error("bit count changed"); // R6
    for (int j = 0; j < WIDTH; j++) begin
      AST_ONE_DRIVER: assert ($countones(en[j]) == 1) else $error("column drivers"); // R4
    end
  end
endmodule

bind xbar_rotator xbar_rotator_chk #(.WIDTH(WIDTH)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .data_o (data_o),
  .sel    (amt_sel),
  .en     (xp_en)
);

// File: tb/xbar_rotator_tb.sv
`timescale 1ns/1ps
module xbar_rotator_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0]  d8;
  logic [2:0]  a8;
  logic [7:0]  y8;
  logic [15:0] d16;
  logic [3:0]  a16;
  logic [15:0] y16;

  xbar_rotator #(.WIDTH(8)) dut_i (
    .data_i (d8),
    .amt_i  (a8),
    .data_o (y8)
  );

  xbar_rotator #(.WIDTH(16)) dut16_i (
    .data_i (d16),
    .amt_i  (a16),
    .data_o (y16)
  );

  logic [31:0] seed = 32'h1badf00d;

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Independent reference: bit-by-bit index arithmetic.
  function automatic logic [15:0] model(input logic [15:0] d, input int k, input int n);
    logic [15:0] r;
    r = '0;
    for (int j = 0; j < n; j++) r[j] = d[(j + k) % n];
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic put8(input logic [7:0] d, input int k);
    @(negedge clk);
    d8 = d;
    a8 = 3'(k);
    #2;
  endtask

  task automatic put16(input logic [15:0] d, input int k);
    @(negedge clk);
    d16 = d;
    a16 = 4'(k);
    #2;
  endtask

  task automatic t_idle_state();
    put8(8'h00, 0);
    check("R2 idle 8", {8'h0, y8}, 16'h0);
    put16(16'h0, 0);
    check("R2 idle 16", y16, 16'h0);
  endtask

  task automatic t_passthrough();
    logic [7:0] pats [4] = '{8'h5a, 8'hc3, 8'h01, 8'hfe};
    foreach (pats[p]) begin
      put8(pats[p], 0);
      check("R2 pass", {8'h0, y8}, {8'h0, pats[p]});
    end
  endtask

  task automatic t_walking_one();
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 8; i++) begin
        put8(8'(1 << i), k);
        check("R3 single bit moves", {8'h0, y8}, 16'(1 << ((i - k + 8) % 8)));
      end
    end
  endtask

  task automatic t_corners();
    logic [7:0] pats [4] = '{8'hff, 8'haa, 8'h80, 8'h0f};
    foreach (pats[p]) begin
      for (int k = 0; k < 8; k++) begin
        put8(pats[p], k);
        check("R1 corner", {8'h0, y8}, model({8'h0, pats[p]}, k, 8));
        check("R6 popcount", 16'($countones(y8)), 16'($countones(pats[p])));
      end
    end
    for (int k = 0; k < 8; k++) begin
      put8(8'hff, k);
      check("R4 all ones", {8'h0, y8}, 16'h00ff);
      put8(8'h00, k);
      check("R4 all zeros", {8'h0, y8}, 16'h0000);
    end
  endtask

  task automatic t_random8();
    for (int n = 0; n < 24; n++) begin
      seed = next_rand(seed);
      for (int k = 0; k < 8; k++) begin
        put8(seed[7:0], k);
        check("R1 random 8", {8'h0, y8}, model({8'h0, seed[7:0]}, k, 8));
      end
    end
  endtask

  task automatic t_wide16();
    for (int n = 0; n < 16; n++) begin
      seed = next_rand(seed);
      for (int k = 0; k < 16; k++) begin
        put16(seed[15:0], k);
        check("R7 width 16", y16, model(seed[15:0], k, 16));
      end
    end
    put16(16'h8001, 15);
    check("R7 wrap 16", y16, 16'h0003);
  endtask

  task automatic t_no_clock_response();
    @(posedge clk);
    #3;
    d8 = 8'h81; a8 = 3'd1;
    #1;
    check("R5 data change", {8'h0, y8}, 16'h00c0);
    a8 = 3'd7;
    #1;
    check("R5 count change", {8'h0, y8}, 16'h0003);
  endtask

  initial begin
    d8 = '0; a8 = '0; d16 = '0; a16 = '0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_passthrough();
    t_walking_one();
    t_corners();
    t_random8();
    t_wide16();
    t_no_clock_response();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule